// File: doc/BRIEF.md
# System Control Status and Cause Registers

This block holds the two privileged 32-bit control registers of a processor core: a status register that carries the operating mode, the interrupt enables and the address-segment enables, and a cause register that carries the software interrupt requests, the count-disable bit and the watch-pending bit. Software writes either register through one write port: an enable, a select and a data word. Each register merges the data under its own set of writable bits. A further set of rules, chosen by two static revision inputs, can refuse parts of a write.

Some writes also act outside the block. A change of the count-disable bit drives a count-stop line to the timer. A change of either software interrupt bit drives the matching request line to the interrupt controller. When a status write turns off an address-segment enable that was on, the block sends a one-cycle flush pulse to the TLB. Both registers can be read back through a combinational select.

Top module: `sysctl_regs`

## Requirements
- R1: While reset is asserted, status reads 0x00400004 (bit 22 boot-vector select and bit 2 error level set, all else clear), cause reads 0, and count_stop, soft_irq and tlb_flush are all 0.
- R2: A status write (wr_sel=0) stores (old AND NOT M) OR (data AND M). M is the parameter STATUS_WMASK (default 0x0058FFFF), reduced by R3 and R4 when rev6_en is 1.
- R3: When rev6_en is 1 and both bits of the mode field [4:3] are writable, a status write whose data has field [4:3] equal to 3 leaves that field unchanged. With rev6_en at 0 the value 3 is stored.
- R4: When rev6_en is 1, writing 1 to status bit 20 (soft-reset flag) or bit 19 (non-maskable flag) leaves that bit unchanged. Writing 0 clears it.
- R5: When rev6_en is 1, the segment enables in a status write are chained: bit 7 (kernel) at 0 forces bit 6 (supervisor) to 0, and bit 6 at 0 forces bit 5 (user) to 0. With rev6_en at 0 they are stored as written.
- R6: tlb_flush is 1 for exactly the cycle after a status write that cleared at least one of status bits 7, 6, 5 that had been 1. It is 0 otherwise.
- R7: A cause write (wr_sel=1) changes only bits 9, 8 (software interrupts 1 and 0), 22 (watch pending) and 23 (interrupt vector select). It also changes bit 27 (count disable) when rev2_en is 1. All other cause bits stay 0.
- R8: When rev6_en is 1, writing 1 to cause bit 22 leaves it unchanged. Writing 0 clears it.
- R9: A cause write that flips bit 27 sets count_stop to the new bit value, visible from the clock edge that stores the write.
- R10: For each of cause bits 8 and 9 that a write changes, soft_irq[0] or soft_irq[1] takes the new value, visible from the clock edge that stores the write.
- R11: rd_data shows status when rd_sel=0 and cause when rd_sel=1, combinationally and in the same cycle.
- R12: With wr_en at 0, wr_sel and wr_data change neither register nor any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rev2_en | input | 1 | Static: makes the count-disable bit writable |
| rev6_en | input | 1 | Static: turns on the refuse, clear-only and chaining rules |
| wr_en | input | 1 | Software write strobe |
| wr_sel | input | 1 | Write target: 0 status, 1 cause |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read source: 0 status, 1 cause |
| rd_data | output | 32 | Selected register value |
| count_stop | output | 1 | Stop request to the count timer |
| soft_irq | output | 2 | Software interrupt request lines |
| tlb_flush | output | 1 | One-cycle TLB flush request |

## Verification
The bench uses the default STATUS_WMASK of 0x0058FFFF. That mask makes the mode field, all three segment enables and both clear-only status flags writable, so every release-6 write rule can be reached. The bench switches rev2_en and rev6_en between writes. This lets the same data word be stored once without the rules and once with them, so each refusal is seen against a state that could have changed. A clear-only bit is first set with the rules off, then written with them on.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int REG_W = 32;

  // status field positions
  localparam int ST_IE   = 0;
  localparam int ST_ERL  = 2;
  localparam int ST_MODE_LO = 3;
  localparam int ST_MODE_HI = 4;
  localparam int ST_UEN  = 5;
  localparam int ST_SEN  = 6;
  localparam int ST_KEN  = 7;
  localparam int ST_NMIF = 19;
  localparam int ST_SRF  = 20;
  localparam int ST_BOOT = 22;

  // cause field positions
  localparam int CA_SWI0 = 8;
  localparam int CA_WPND = 22;
  localparam int CA_IVS  = 23;
  localparam int CA_CDIS = 27;

  localparam logic [REG_W-1:0] ST_RESET_VAL =
    (REG_W'(1) << ST_BOOT) | (REG_W'(1) << ST_ERL);
  localparam logic [REG_W-1:0] ST_SEG_BITS =
    (REG_W'(1) << ST_KEN) | (REG_W'(1) << ST_SEN) | (REG_W'(1) << ST_UEN);
  localparam logic [REG_W-1:0] ST_STICKY_BITS =
    (REG_W'(1) << ST_SRF) | (REG_W'(1) << ST_NMIF);
  localparam logic [REG_W-1:0] ST_MODE_BITS =
    (REG_W'(1) << ST_MODE_HI) | (REG_W'(1) << ST_MODE_LO);

  localparam logic [REG_W-1:0] CA_BASE_WMASK =
    (REG_W'(3) << CA_SWI0) | (REG_W'(1) << CA_WPND) | (REG_W'(1) << CA_IVS);
  localparam logic [REG_W-1:0] CA_CDIS_BIT = REG_W'(1) << CA_CDIS;
  localparam logic [REG_W-1:0] CA_WPND_BIT = REG_W'(1) << CA_WPND;
endpackage

// File: rtl/sysctl_status_unit.sv
module sysctl_status_unit
  import sysctl_pkg::*;
#(
  parameter logic [REG_W-1:0] WMASK = 32'h0058_FFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rev6_en,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] q,
  output logic             flush
);
  localparam logic SUPV_IMPL = WMASK[ST_MODE_HI] & WMASK[ST_MODE_LO];
  localparam logic SEG_ALL_W = WMASK[ST_KEN] & WMASK[ST_SEN] & WMASK[ST_UEN];

  logic [REG_W-1:0] data_adj;
  logic [REG_W-1:0] eff_mask;
  logic [REG_W-1:0] q_nxt;
  logic             flush_nxt;
  logic             k_c, s_c, u_c;

  // segment enable chaining and write mask adjustment
  always_comb begin
    k_c = wdata[ST_KEN];
    s_c = wdata[ST_SEN] & k_c;
    u_c = wdata[ST_UEN] & s_c;
    data_adj = wdata;
    eff_mask = WMASK;
    if (rev6_en) begin
      data_adj[ST_KEN] = k_c;
      data_adj[ST_SEN] = s_c;
      data_adj[ST_UEN] = u_c;
      if (SUPV_IMPL && (wdata[ST_MODE_HI:ST_MODE_LO] == 2'b11)) begin
        eff_mask = eff_mask & ~ST_MODE_BITS;
      end
      eff_mask = eff_mask & ~(wdata & ST_STICKY_BITS);
    end
  end

  always_comb begin
    q_nxt     = q;
    flush_nxt = 1'b0;
    if (we) begin
      q_nxt     = (q & ~eff_mask) | (data_adj & eff_mask);
      flush_nxt = |((q ^ q_nxt) & q & ST_SEG_BITS);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= ST_RESET_VAL;
      flush <= 1'b0;
    end else begin
      q     <= q_nxt;
      flush <= flush_nxt;
    end
  end

  // R6
  flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> ($past(we) && (($past(q) & ~q & ST_SEG_BITS) != '0)));

  // R4
  srf_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && rev6_en && !q[ST_SRF]) |=> !q[ST_SRF]);

  // R4
  nmif_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && rev6_en && !q[ST_NMIF]) |=> !q[ST_NMIF]);

  // R3
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && rev6_en && SUPV_IMPL && (wdata[ST_MODE_HI:ST_MODE_LO] == 2'b11))
      |=> $stable(q[ST_MODE_HI:ST_MODE_LO]));

  generate
    if (SEG_ALL_W) begin : g_chain_chk
      // R5
      seg_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && rev6_en) |=> ((!q[ST_SEN] || q[ST_KEN]) && (!q[ST_UEN] || q[ST_SEN])));
    end
  endgenerate
endmodule

// File: rtl/sysctl_cause_unit.sv
module sysctl_cause_unit
  import sysctl_pkg::*;
#(
  parameter int NUM_SWI = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rev2_en,
  input  logic               rev6_en,
  input  logic               we,
  input  logic [REG_W-1:0]   wdata,
  output logic [REG_W-1:0]   q,
  output logic               cnt_stop,
  output logic [NUM_SWI-1:0] swi
);
  localparam logic [REG_W-1:0] ALL_WMASK = CA_BASE_WMASK | CA_CDIS_BIT;

  logic [REG_W-1:0]   eff_mask;
  logic [REG_W-1:0]   q_nxt;
  logic [REG_W-1:0]   diff;
  logic               cnt_stop_nxt;
  logic [NUM_SWI-1:0] swi_nxt;

  always_comb begin
    eff_mask = CA_BASE_WMASK;
    if (rev2_en) eff_mask = eff_mask | CA_CDIS_BIT;
    if (rev6_en) eff_mask = eff_mask & ~(wdata & CA_WPND_BIT);
    q_nxt = we ? ((q & ~eff_mask) | (wdata & eff_mask)) : q;
    diff  = q ^ q_nxt;
  end

  always_comb begin
    cnt_stop_nxt = cnt_stop;
    if (diff[CA_CDIS]) cnt_stop_nxt = q_nxt[CA_CDIS];
  end

  generate
    for (genvar i = 0; i < NUM_SWI; i++) begin : g_swi
      always_comb begin
        swi_nxt[i] = swi[i];
        if (diff[CA_SWI0 + i]) swi_nxt[i] = q_nxt[CA_SWI0 + i];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q        <= '0;
      cnt_stop <= 1'b0;
      swi      <= '0;
    end else begin
      q        <= q_nxt;
      cnt_stop <= cnt_stop_nxt;
      swi      <= swi_nxt;
    end
  end

  // R7
  fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q & ~ALL_WMASK) == '0);

  // R8
  wpnd_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && rev6_en && !q[CA_WPND]) |=> !q[CA_WPND]);

  // R9
  cnt_stop_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_stop == q[CA_CDIS]);

  // R10
  swi_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swi == q[CA_SWI0 +: NUM_SWI]);
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter logic [31:0] STATUS_WMASK = 32'h0058_FFFF,
  parameter int          NUM_SWI      = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rev2_en,
  input  logic               rev6_en,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [31:0]        wr_data,
  input  logic               rd_sel,
  output logic [31:0]        rd_data,
  output logic               count_stop,
  output logic [NUM_SWI-1:0] soft_irq,
  output logic               tlb_flush
);
  logic             st_we, ca_we;
  logic [REG_W-1:0] st_q, ca_q;

  assign st_we = wr_en & ~wr_sel;
  assign ca_we = wr_en &  wr_sel;

  sysctl_status_unit #(.WMASK(STATUS_WMASK)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .rev6_en (rev6_en),
    .we      (st_we),
    .wdata   (wr_data),
    .q       (st_q),
    .flush   (tlb_flush)
  );

  sysctl_cause_unit #(.NUM_SWI(NUM_SWI)) u_cause (
    .clk      (clk),
    .rst_n    (rst_n),
    .rev2_en  (rev2_en),
    .rev6_en  (rev6_en),
    .we       (ca_we),
    .wdata    (wr_data),
    .q        (ca_q),
    .cnt_stop (count_stop),
    .swi      (soft_irq)
  );

  always_comb begin
    rd_data = rd_sel ? ca_q : st_q;
  end

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(st_q) && $stable(ca_q) && !tlb_flush));
endmodule

// File: tb/sysctl_regs_tb.sv
`timescale 1ns/1ps
module sysctl_regs_tb;
  localparam int NV = 20;
  localparam int VW = 103;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rev2_en, rev6_en, wr_en, wr_sel, rd_sel;
  logic [31:0] wr_data, rd_data;
  logic        count_stop, tlb_flush;
  logic [1:0]  soft_irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  sysctl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .rev2_en(rev2_en), .rev6_en(rev6_en),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .count_stop(count_stop), .soft_irq(soft_irq),
    .tlb_flush(tlb_flush)
  );

  // {rev2, rev6, sel, data, exp_status, exp_cause, exp_irq, exp_cstop, exp_flush}
  localparam logic [VW-1:0] VECS [0:NV-1] = '{
    {1'b0,1'b0,1'b0,32'h000000E0,32'h000000E0,32'h00000000,2'b00,1'b0,1'b0},
    {1'b0,1'b0,1'b0,32'h00000020,32'h00000020,32'h00000000,2'b00,1'b0,1'b1},
    {1'b0,1'b1,1'b0,32'h000000A0,32'h00000080,32'h00000000,2'b00,1'b0,1'b1},
    {1'b0,1'b1,1'b0,32'h000000E0,32'h000000E0,32'h00000000,2'b00,1'b0,1'b0},
    {1'b0,1'b1,1'b0,32'h00000018,32'h00000000,32'h00000000,2'b00,1'b0,1'b1},
    {1'b0,1'b0,1'b0,32'h00000018,32'h00000018,32'h00000000,2'b00,1'b0,1'b0},
    {1'b0,1'b1,1'b0,32'h00000008,32'h00000008,32'h00000000,2'b00,1'b0,1'b0},
    {1'b0,1'b0,1'b0,32'h00180000,32'h00180000,32'h00000000,2'b00,1'b0,1'b0},
    {1'b0,1'b1,1'b0,32'h00000000,32'h00000000,32'h00000000,2'b00,1'b0,1'b0},
    {1'b0,1'b1,1'b0,32'h00180001,32'h00000001,32'h00000000,2'b00,1'b0,1'b0},
    {1'b0,1'b0,1'b0,32'h00400000,32'h00400000,32'h00000000,2'b00,1'b0,1'b0},
    {1'b0,1'b0,1'b0,32'h00100000,32'h00100000,32'h00000000,2'b00,1'b0,1'b0},
    {1'b0,1'b1,1'b0,32'h00100000,32'h00100000,32'h00000000,2'b00,1'b0,1'b0},
    {1'b0,1'b0,1'b1,32'hFFFFFFFF,32'h00100000,32'h00C00300,2'b11,1'b0,1'b0},
    {1'b1,1'b0,1'b1,32'h08000100,32'h00100000,32'h08000100,2'b01,1'b1,1'b0},
    {1'b1,1'b1,1'b1,32'h08400200,32'h00100000,32'h08000200,2'b10,1'b1,1'b0},
    {1'b1,1'b0,1'b1,32'h08400000,32'h00100000,32'h08400000,2'b00,1'b1,1'b0},
    {1'b1,1'b1,1'b1,32'h00400000,32'h00100000,32'h00400000,2'b00,1'b0,1'b0},
    {1'b1,1'b1,1'b1,32'h00000000,32'h00100000,32'h00000000,2'b00,1'b0,1'b0},
    {1'b0,1'b0,1'b1,32'h08000000,32'h00100000,32'h00000000,2'b00,1'b0,1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, got, exp);
    end
  endtask

  task automatic read_both(output logic [31:0] st, output logic [31:0] ca);
    rd_sel = 1'b0;
    #0.5 st = rd_data;
    rd_sel = 1'b1;
    #0.5 ca = rd_data;
    rd_sel = 1'b0;
  endtask

  task automatic check_all(input string pfx, input logic [31:0] est, input logic [31:0] eca,
                           input logic [1:0] eirq, input logic ecs, input logic efl);
    logic [31:0] st, ca;
    chk({pfx, " flush R6"}, {31'b0, tlb_flush}, {31'b0, efl});
    chk({pfx, " count_stop R9"}, {31'b0, count_stop}, {31'b0, ecs});
    chk({pfx, " soft_irq R10"}, {30'b0, soft_irq}, {30'b0, eirq});
    read_both(st, ca);
    chk({pfx, " status R2,R3,R4,R5,R11"}, st, est);
    chk({pfx, " cause R7,R8,R11"}, ca, eca);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rev2_en = 1'b0; rev6_en = 1'b0;
    wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0; rd_sel = 1'b0;
    repeat (3) @(negedge clk);
    check_all("reset R1", 32'h00400004, 32'h0, 2'b00, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("post-reset R1", 32'h00400004, 32'h0, 2'b00, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VECS[i];
      @(negedge clk);
      rev2_en = v[102]; rev6_en = v[101]; wr_sel = v[100];
      wr_data = v[99:68]; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      check_all($sformatf("vec%0d", i), v[67:36], v[35:4], v[3:2], v[1], v[0]);
    end

    // R12: strobe low, data and select present; nothing may move
    rev2_en = 1'b1; rev6_en = 1'b0;
    for (int s = 0; s < 2; s++) begin
      @(negedge clk);
      wr_sel = s[0]; wr_data = 32'hFFFFFFFF; wr_en = 1'b0;
      @(negedge clk);
      check_all("idle R12", 32'h00100000, 32'h0, 2'b00, 1'b0, 1'b0);
    end

    // R6: flush lasts exactly one cycle
    @(negedge clk);
    wr_sel = 1'b0; wr_data = 32'h000000E0; wr_en = 1'b1;
    @(negedge clk);
    wr_data = 32'h00000000;
    @(negedge clk);
    wr_en = 1'b0;
    chk("flush on clear R6", {31'b0, tlb_flush}, 32'h1);
    @(negedge clk);
    chk("flush single cycle R6", {31'b0, tlb_flush}, 32'h0);

    // R1: reset asserted mid-run with outputs non-zero
    @(negedge clk);
    wr_sel = 1'b1; wr_data = 32'h08000300; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    check_all("pre-reset R9", 32'h0, 32'h08000300, 2'b11, 1'b1, 1'b0);
    rst_n = 1'b0;
    #0.5;
    check_all("mid reset R1", 32'h00400004, 32'h0, 2'b00, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule